// File: doc/BRIEF.md
# Bus Cycle Utilization Monitor

This block observes a shared system bus on every bus clock and sorts each cycle into one of three classes. An idle cycle is one that no agent drove. A useful cycle is a driven cycle that completed a data transfer. A busy cycle is a driven cycle that the target refused, so it will have to be retried. The block keeps one counter per class, and the three counters run side by side.

Software arms the block with a start strobe. This opens a single measurement window of fixed length, 65536 bus cycles by default. At the nominal 125 ns bus cycle that is 8.192 ms. When the window ends, the block stops counting on its own, drops `running` and raises `done`. The three counts then stay frozen until software reads them and starts a new window. Only one window can be open at a time. A start that arrives while a window is still open is refused and recorded in a sticky flag.

Top module: `bus_util_monitor`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to its rest state after that edge: all three counts are 0 and `running`, `done` and `start_rejected` are 0.
- R2: A `start_req` sampled high while `running` is low is accepted. After that edge `running` is 1, `done` is 0, `start_rejected` is 0 and all three counts are 0.
- R3: A window counts exactly WINDOW_LEN (default 65536) bus cycles, at the WINDOW_LEN clock edges that follow the accepting edge. `running` stays 1 through the last counted edge. `running` falls and `done` rises at that last edge, with no software action.
- R4: A counted cycle with `bus_valid` = 0 adds one to the idle count, whatever the value of `bus_busy`.
- R5: A counted cycle with `bus_valid` = 1 and `bus_busy` = 0 adds one to the useful count.
- R6: A counted cycle with `bus_valid` = 1 and `bus_busy` = 1 adds one to the busy count.
- R7: When `done` rises, idle + useful + busy equals WINDOW_LEN.
- R8: A `start_req` sampled while `running` is 1 is refused. This includes the window's last counted edge. The window runs on and the counts are not cleared. `start_rejected` goes to 1 and stays 1 until the next accepted start.
- R9: While `running` is 0 and no start is accepted, the three counts hold their values whatever the bus inputs do.
- R10: Each count is $clog2(WINDOW_LEN+1) bits wide (17 by default), so a window in which every cycle falls into one class reports exactly WINDOW_LEN for that class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_req | input | 1 | One-cycle start strobe from the register interface |
| bus_valid | input | 1 | Some agent drove the bus in this cycle |
| bus_busy | input | 1 | The cycle was refused and will be retried |
| running | output | 1 | A measurement window is open |
| done | output | 1 | The last window has completed and the counts are frozen |
| start_rejected | output | 1 | Sticky: a start was refused while a window was open |
| idle_count | output | 17 | Idle cycles in the current or last window |
| useful_count | output | 17 | Useful cycles in the current or last window |
| busy_count | output | 17 | Busy cycles in the current or last window |

## Verification
Each result registers at one clock edge and is sampled at the following falling edge. A start driven before edge E shows `running` high and zeroed counts at the falling edge after E. Bus inputs driven before a counted edge appear in the counts half a cycle after that edge. The bench therefore checks `running` at every falling edge inside the window, and checks `done` and the final counts one falling edge after the WINDOW_LEN-th counted edge. Refusals are checked one falling edge after the strobe, once mid-window and once on the last counted edge, together with the partial count sum expected at that point.

// File: rtl/bum_pkg.sv
// Package: shared types for the bus cycle utilization monitor.
// Assumes the class order below is also the order of the counter vector.
package bum_pkg;

    typedef enum logic [1:0] {
        CLS_IDLE   = 2'd0,
        CLS_USEFUL = 2'd1,
        CLS_BUSY   = 2'd2
    } cycle_class_e;

    localparam int NUM_CLASSES = 3;

endpackage

// File: rtl/bum_classifier.sv
// Module: bum_classifier
// Purpose: turn the two per-cycle bus status bits into a one-hot class vector.
// Assumes: bus_busy has meaning only when bus_valid is high; otherwise the
// cycle is idle.
module bum_classifier
    import bum_pkg::*;
(
    input  logic                   bus_valid,
    input  logic                   bus_busy,
    output logic [NUM_CLASSES-1:0] class_hit
);

    cycle_class_e cls;

    // Decide the class of the current cycle.
    always_comb begin
        if (!bus_valid)
            cls = CLS_IDLE;
        else if (bus_busy)
            cls = CLS_BUSY;
        else
            cls = CLS_USEFUL;
    end

    // Expand the class into one strobe per counter.
    always_comb begin
        class_hit = '0;
        class_hit[cls] = 1'b1;
    end

endmodule

// File: rtl/bum_class_counters.sv
// Module: bum_class_counters
// Purpose: one saturating-free counter per cycle class, cleared on start.
// Assumes: the window controller never enables counting for more than LIMIT
// cycles between clears, so CNT_W bits are enough.
module bum_class_counters #(
    parameter int NUM   = 3,
    parameter int LIMIT = 65536,
    parameter int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      enable,
    input  logic [NUM-1:0]            hit,
    output logic [NUM-1:0][CNT_W-1:0] counts
);

    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);

    for (genvar k = 0; k < NUM; k++) begin : g_cnt
        // Clear on accepted start, otherwise add this class's strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)
                counts[k] <= '0;
            else if (clear)
                counts[k] <= '0;
            else if (enable && hit[k])
                counts[k] <= counts[k] + CNT_W'(1);
        end

        a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            counts[k] <= LIMIT_V);

        a_r9_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
            (!enable && !clear) |=> $stable(counts[k]));
    end

endmodule

// File: rtl/bum_window_ctrl.sv
// Module: bum_window_ctrl
// Purpose: open a one-shot window of WINDOW_LEN cycles on an accepted start,
// close it by itself, and refuse starts while it is open.
// Assumes: start_req is a single-cycle strobe from the register interface.
module bum_window_ctrl #(
    parameter int WINDOW_LEN = 65536,
    parameter int CNT_W      = $clog2(WINDOW_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    output logic running,
    output logic done,
    output logic start_rejected,
    output logic clear_counts
);

    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(WINDOW_LEN - 1);

    logic [CNT_W-1:0] pos;
    logic             accept;

    // A start is taken only when no window is open.
    assign accept       = start_req && !running;
    assign clear_counts = accept;

    // Window state: open, advance position, close on the last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            done    <= 1'b0;
            pos     <= '0;
        end else if (accept) begin
            running <= 1'b1;
            done    <= 1'b0;
            pos     <= '0;
        end else if (running) begin
            pos <= pos + CNT_W'(1);
            if (pos == LAST_POS) begin
                running <= 1'b0;
                done    <= 1'b1;
            end
        end
    end

    // Sticky refusal flag, cleared by the next accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            start_rejected <= 1'b0;
        else if (accept)
            start_rejected <= 1'b0;
        else if (start_req && running)
            start_rejected <= 1'b1;
    end

    a_r2_accept_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && !running) |=> (running && !done && !start_rejected));

    a_r8_refuse_keeps_window: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && running && pos != LAST_POS) |=> (running && start_rejected));

    a_r3_exclusive_state: assert property (@(posedge clk) disable iff (!rst_n)
        !(running && done));

    a_r3_close_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        (running && pos == LAST_POS) |=> (!running && done));

endmodule

// File: rtl/bus_util_monitor.sv
// Module: bus_util_monitor
// Purpose: classify every bus cycle as idle, useful or busy and count each
// class over one self-terminating window armed by software.
// Assumes: bus_valid and bus_busy are synchronous to clk; counts are read
// while done is high and stay frozen until the next accepted start.
module bus_util_monitor
    import bum_pkg::*;
#(
    parameter int WINDOW_LEN = 65536,
    parameter int CNT_W      = $clog2(WINDOW_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             bus_valid,
    input  logic             bus_busy,
    output logic             running,
    output logic             done,
    output logic             start_rejected,
    output logic [CNT_W-1:0] idle_count,
    output logic [CNT_W-1:0] useful_count,
    output logic [CNT_W-1:0] busy_count
);

    logic [NUM_CLASSES-1:0]            class_hit;
    logic [NUM_CLASSES-1:0][CNT_W-1:0] counts;
    logic                              clear_counts;

    bum_classifier u_classify (
        .bus_valid (bus_valid),
        .bus_busy  (bus_busy),
        .class_hit (class_hit)
    );

    bum_window_ctrl #(
        .WINDOW_LEN (WINDOW_LEN),
        .CNT_W      (CNT_W)
    ) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_req      (start_req),
        .running        (running),
        .done           (done),
        .start_rejected (start_rejected),
        .clear_counts   (clear_counts)
    );

    bum_class_counters #(
        .NUM   (NUM_CLASSES),
        .LIMIT (WINDOW_LEN),
        .CNT_W (CNT_W)
    ) u_counts (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (clear_counts),
        .enable (running),
        .hit    (class_hit),
        .counts (counts)
    );

    assign idle_count   = counts[CLS_IDLE];
    assign useful_count = counts[CLS_USEFUL];
    assign busy_count   = counts[CLS_BUSY];

    a_r7_total_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ((CNT_W + 2)'(idle_count) + (CNT_W + 2)'(useful_count)
                         + (CNT_W + 2)'(busy_count)) == (CNT_W + 2)'(WINDOW_LEN));

    a_r4_idle_step: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !start_req && !bus_valid) |=> idle_count == $past(idle_count) + CNT_W'(1));

    a_r6_busy_step: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !start_req && bus_valid && bus_busy) |=> busy_count == $past(busy_count) + CNT_W'(1));

endmodule

// File: tb/tb_bus_util_monitor.sv
module tb_bus_util_monitor;

    localparam int WIN   = 65536;
    localparam int CNT_W = $clog2(WIN + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_req = 1'b0;
    logic             bus_valid = 1'b0;
    logic             bus_busy = 1'b0;
    logic             running, done, start_rejected;
    logic [CNT_W-1:0] idle_count, useful_count, busy_count;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int exp_idle, exp_useful, exp_busy;

    bus_util_monitor #(.WINDOW_LEN(WIN)) dut (
        .clk(clk), .rst_n(rst_n), .start_req(start_req),
        .bus_valid(bus_valid), .bus_busy(bus_busy),
        .running(running), .done(done), .start_rejected(start_rejected),
        .idle_count(idle_count), .useful_count(useful_count), .busy_count(busy_count)
    );

    always #10 clk = ~clk;

    // Expected class of a cycle: 0 idle, 1 useful, 2 busy.
    function automatic int exp_class(input logic v, input logic b);
        if (!v) return 0;
        return b ? 2 : 1;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic account(input logic v, input logic b);
        case (exp_class(v, b))
            0: exp_idle++;
            1: exp_useful++;
            default: exp_busy++;
        endcase
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        int unsigned seed;
        int run_bad;
        int prev_i, prev_u, prev_b;
        seed = $urandom(32'h5eed_1234);
        repeat (3) @(negedge clk);
        // R1 rest state
        check(!running && !done && !start_rejected, "R1 flags", {running, done, start_rejected}, 0);
        check(idle_count == 0 && useful_count == 0 && busy_count == 0, "R1 counts",
              int'(idle_count) + int'(useful_count) + int'(busy_count), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Window 1: random traffic, refusal mid-window.
        start_req = 1'b1;
        bus_valid = 1'b1;
        @(negedge clk);
        check(running && !done && !start_rejected, "R2 accept", {running, done, start_rejected}, 4);
        check(idle_count == 0 && useful_count == 0 && busy_count == 0, "R2 cleared",
              int'(idle_count) + int'(useful_count) + int'(busy_count), 0);
        start_req = 1'b0;
        exp_idle = 0; exp_useful = 0; exp_busy = 0;
        run_bad = 0;
        for (int i = 1; i <= WIN; i++) begin
            if (!running) run_bad++;
            if (i == 102) begin
                // R8: the strobe at edge 101 was refused; sum equals 101 counted edges.
                check(running && start_rejected, "R8 refused mid", {running, start_rejected}, 3);
                check(int'(idle_count) == exp_idle && int'(useful_count) == exp_useful
                      && int'(busy_count) == exp_busy, "R8 not cleared",
                      int'(idle_count) + int'(useful_count) + int'(busy_count), 101);
            end
            start_req = (i == 101);
            bus_valid = ($urandom % 100) < 60;
            bus_busy  = ($urandom % 100) < 40;
            account(bus_valid, bus_busy);
            @(negedge clk);
        end
        start_req = 1'b0;
        check(run_bad == 0, "R3 running through window", run_bad, 0);
        check(!running && done, "R3 self stop", {running, done}, 1);
        check(int'(idle_count) == exp_idle, "R4 idle", int'(idle_count), exp_idle);
        check(int'(useful_count) == exp_useful, "R5 useful", int'(useful_count), exp_useful);
        check(int'(busy_count) == exp_busy, "R6 busy", int'(busy_count), exp_busy);
        check(int'(idle_count) + int'(useful_count) + int'(busy_count) == WIN, "R7 total",
              int'(idle_count) + int'(useful_count) + int'(busy_count), WIN);
        check(start_rejected, "R8 sticky", start_rejected, 1);

        // R9: frozen while stopped.
        prev_i = idle_count; prev_u = useful_count; prev_b = busy_count;
        for (int i = 0; i < 40; i++) begin
            bus_valid = $urandom % 2;
            bus_busy  = $urandom % 2;
            @(negedge clk);
        end
        check(int'(idle_count) == prev_i && int'(useful_count) == prev_u
              && int'(busy_count) == prev_b && done, "R9 frozen", int'(idle_count), prev_i);

        // Window 2: every cycle useful; refusal on the last counted edge.
        start_req = 1'b1;
        @(negedge clk);
        check(!start_rejected && running, "R8 cleared by accept", start_rejected, 0);
        check(idle_count == 0 && useful_count == 0 && busy_count == 0 && !done, "R2 restart",
              int'(useful_count), 0);
        for (int i = 1; i <= WIN; i++) begin
            start_req = (i == WIN);
            bus_valid = 1'b1;
            bus_busy  = 1'b0;
            @(negedge clk);
        end
        start_req = 1'b0;
        check(int'(useful_count) == WIN && idle_count == 0 && busy_count == 0, "R10 full width",
              int'(useful_count), WIN);
        check(done && !running && start_rejected, "R8 refused at last edge",
              {done, running, start_rejected}, 5);
        @(negedge clk);
        check(int'(useful_count) == WIN && done, "R9 held after last-edge refusal",
              int'(useful_count), WIN);
        summary();
    end

endmodule